// File: doc/BRIEF.md
# Lane-Mask-Aware Register Reservation Table

This block keeps, for every warp, a small table of register writes that have been issued but have not yet retired. Each entry holds a register number, the active-lane mask of the writing instruction, a reference count and the value of a free-running cycle counter at the moment the entry was created. An issue stage reserves an entry when it sends out a writing instruction. It releases the entry when that write completes.

Before issuing, the issue stage puts a candidate instruction's operand numbers and active mask on the check port. These are up to eight operands: two destinations, three sources, a predicate and two address registers. The block reports a hazard only when some pending write names one of those registers and also covers at least one lane that the candidate has active. A write to disjoint lanes of the same register therefore does not stall the candidate.

For diagnostics, the check also reports the lowest-indexed matching entry. It gives the number of lanes that entry shares with the candidate and the cycle at which that entry was reserved. The table has no state machine. Its only sequencing is the per-entry life cycle: the entry is free, then allocated, then counted up and down, then freed again.

Top module: `lane_resv_table`

## Requirements
- R1: While reset is held, every entry is free, `haz`, `haz_lanes`, `haz_cyc` and `res_ovf` are 0, and `now_cycle` is 0.
- R2: A reserve whose register and exact mask match no valid entry of its warp allocates the lowest-indexed free entry with a count of 1.
- R3: A reserve whose register and mask equal those of a valid entry increments that entry's count instead of allocating, so the same number of releases is needed to clear it.
- R4: A release matching register and exact mask decrements the count and frees the entry when the count reaches 0.
- R5: A release that matches no entry exactly, including one with the same register but a different mask, changes nothing.
- R6: `haz` is 1 only when a valid entry of the checked warp has a register equal to a collected operand, and its mask ANDed with `chk_mask` is nonzero. Entries of other warps never count.
- R7: Operand fields are signed `REG_W`-bit numbers packed with slot k at bits [k*REG_W +: REG_W]. The slots are dst0, dst1, src0, src1, src2, pred, addr0 and addr1. A field of 0 or a negative value is ignored, even when a stored entry holds that value.
- R8: When `haz` is 1, `haz_lanes` is the popcount of the lowest-indexed matching entry's mask ANDed with `chk_mask`. Otherwise `haz_lanes` is 0.
- R9: `now_cycle` increments by one every clock after reset. A new entry records the `now_cycle` value present in its reserve cycle, and `haz_cyc` shows it for the reported entry.
- R10: Some reserves are dropped, and each dropped reserve sets `res_ovf` to 1 for exactly the following cycle. This applies to a reserve that needs a new entry in a full warp table. It also applies to a reserve that would push a count past its maximum of 2^CNT_W-1.
- R11: The check sees the table as it stood at the start of the cycle. A reserve made in the same cycle shows up only from the next cycle.
- R12: A reserve and a release that hit the same entry in the same cycle leave its count unchanged.
- R13: A valid entry never holds a count of 0, so no release can act on an already-zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_vld | input | 1 | Reserve request |
| res_warp | input | WARP_W | Warp of the reserve |
| res_reg | input | REG_W | Register written by the reserving instruction |
| res_mask | input | LANES | Active lanes of the reserving instruction |
| rel_vld | input | 1 | Release request |
| rel_warp | input | WARP_W | Warp of the release |
| rel_reg | input | REG_W | Register whose write retired |
| rel_mask | input | LANES | Lane mask given at reserve time |
| chk_warp | input | WARP_W | Warp of the candidate instruction |
| chk_ops | input | OP_SLOTS*REG_W | Packed candidate operand numbers |
| chk_mask | input | LANES | Candidate's active lanes |
| haz | output | 1 | True data hazard found |
| haz_lanes | output | LN_W | Overlapping lane count of reported entry |
| haz_cyc | output | CYC_W | Reservation cycle of reported entry |
| res_ovf | output | 1 | Previous cycle's reserve was dropped |
| now_cycle | output | CYC_W | Free-running cycle count |

## Verification
The bench fills one warp with two entries on the same register but with disjoint halves of the lanes. It also stores entries whose register values are 0 and negative. A design that matched on the register alone would flag lane-disjoint checks, and one that failed to screen empty or negative operands would flag every check. It reserves the same register and mask repeatedly up to the count limit and then one time more. A count that wrapped would free the entry early, and a design that allocated a second entry instead of counting would need fewer releases than the bench issues. It also aims at two timing cases: a reserve and a check in one cycle, which must not see each other, and a reserve and a release of one entry in one cycle, which must net to zero.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    // Operand slots of a candidate instruction, in packing order on chk_ops.
    typedef enum logic [2:0] {
        OPS_DST0  = 3'd0,
        OPS_DST1  = 3'd1,
        OPS_SRC0  = 3'd2,
        OPS_SRC1  = 3'd3,
        OPS_SRC2  = 3'd4,
        OPS_PRED  = 3'd5,
        OPS_ADDR0 = 3'd6,
        OPS_ADDR1 = 3'd7
    } op_slot_e;

    localparam int unsigned OP_SLOTS = 8;

endpackage

// File: rtl/rrt_cycle_ctr.sv
module rrt_cycle_ctr #(
    parameter int unsigned CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CYC_W-1:0] cyc
);

    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + {{(CYC_W-1){1'b0}}, 1'b1};
    end

    assign cyc = cyc_q;

    // R9: steps by exactly one per clock
    a_r9_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cyc_q == $past(cyc_q) + {{(CYC_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/rrt_warp_bank.sv
module rrt_warp_bank #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned REG_W   = 8,
    parameter int unsigned LANES   = 32,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned CYC_W   = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               res_en,
    input  logic [REG_W-1:0]                   res_reg,
    input  logic [LANES-1:0]                   res_mask,
    input  logic                               rel_en,
    input  logic [REG_W-1:0]                   rel_reg,
    input  logic [LANES-1:0]                   rel_mask,
    input  logic [CYC_W-1:0]                   now_cyc,
    output logic [ENTRIES-1:0]                 ent_vld,
    output logic [ENTRIES-1:0][REG_W-1:0]      ent_reg,
    output logic [ENTRIES-1:0][LANES-1:0]      ent_mask,
    output logic [ENTRIES-1:0][CYC_W-1:0]      ent_cyc,
    output logic                               ovf
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [ENTRIES-1:0]             vld_q, vld_d;
    logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q, cnt_d;
    logic [ENTRIES-1:0][REG_W-1:0]  reg_q, reg_d;
    logic [ENTRIES-1:0][LANES-1:0]  mask_q, mask_d;
    logic [ENTRIES-1:0][CYC_W-1:0]  cyc_q, cyc_d;
    logic                           ovf_q, ovf_d;

    logic [ENTRIES-1:0] res_hit, rel_hit, sat, alloc_sel;
    logic               any_res_hit, tbl_full;

    // Exact-key match of the two request ports against every entry.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            res_hit[e] = res_en && vld_q[e] && (reg_q[e] == res_reg) && (mask_q[e] == res_mask);
            rel_hit[e] = rel_en && vld_q[e] && (reg_q[e] == rel_reg) && (mask_q[e] == rel_mask);
            sat[e]     = (cnt_q[e] == CNT_MAX);
        end
        any_res_hit = |res_hit;
        tbl_full    = &vld_q;
    end

    // Lowest free entry takes a reserve that found no key match.
    always_comb begin
        logic taken;
        taken     = 1'b0;
        alloc_sel = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (res_en && !any_res_hit && !vld_q[e] && !taken) begin
                alloc_sel[e] = 1'b1;
                taken        = 1'b1;
            end
        end
    end

    // Entry life cycle: free -> allocated -> counted -> free.
    always_comb begin
        vld_d  = vld_q;
        cnt_d  = cnt_q;
        reg_d  = reg_q;
        mask_d = mask_q;
        cyc_d  = cyc_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (alloc_sel[e]) begin
                vld_d[e]  = 1'b1;
                cnt_d[e]  = CNT_ONE;
                reg_d[e]  = res_reg;
                mask_d[e] = res_mask;
                cyc_d[e]  = now_cyc;
            end else if (vld_q[e]) begin
                cnt_d[e] = cnt_q[e]
                         + ((res_hit[e] && !sat[e]) ? CNT_ONE : '0)
                         - (rel_hit[e] ? CNT_ONE : '0);
                vld_d[e] = (cnt_d[e] != '0);
            end
        end
        ovf_d = res_en && (any_res_hit ? |(res_hit & sat) : tbl_full);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            cnt_q  <= '0;
            reg_q  <= '0;
            mask_q <= '0;
            cyc_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            vld_q  <= vld_d;
            cnt_q  <= cnt_d;
            reg_q  <= reg_d;
            mask_q <= mask_d;
            cyc_q  <= cyc_d;
            ovf_q  <= ovf_d;
        end
    end

    assign ent_vld  = vld_q;
    assign ent_reg  = reg_q;
    assign ent_mask = mask_q;
    assign ent_cyc  = cyc_q;
    assign ovf      = ovf_q;

    // R2: at most one entry allocated per reserve
    a_r2_alloc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_sel));

    // R10: a reserve into a full table with no match is dropped and flagged
    a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (res_en && !any_res_hit && tbl_full && !rel_en) |=> (ovf_q && $stable(vld_q)));

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent_chk
        // R13: valid entries never sit at count zero
        a_r13_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[e] |-> (cnt_q[e] != '0));

        // R4: last release frees the entry
        a_r4_free_on_last: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_hit[e] && !res_hit[e] && cnt_q[e] == CNT_ONE) |=> !vld_q[e]);

        // R3: matching reserve adds one reference
        a_r3_ref_up: assert property (@(posedge clk) disable iff (!rst_n)
            (res_hit[e] && !rel_hit[e] && !sat[e]) |=> (cnt_q[e] == $past(cnt_q[e]) + CNT_ONE));

        // R12: reserve and release of one entry in one cycle cancel
        a_r12_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (res_hit[e] && rel_hit[e] && !sat[e]) |=> (vld_q[e] && $stable(cnt_q[e])));
    end

endmodule

// File: rtl/rrt_hazard.sv
module rrt_hazard #(
    parameter int unsigned ENTRIES  = 8,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned LANES    = 32,
    parameter int unsigned CYC_W    = 32,
    parameter int unsigned OP_SLOTS = 8,
    parameter int unsigned LN_W     = 6
) (
    input  logic [ENTRIES-1:0]              ent_vld,
    input  logic [ENTRIES-1:0][REG_W-1:0]   ent_reg,
    input  logic [ENTRIES-1:0][LANES-1:0]   ent_mask,
    input  logic [ENTRIES-1:0][CYC_W-1:0]   ent_cyc,
    input  logic [OP_SLOTS-1:0][REG_W-1:0]  ops,
    input  logic [LANES-1:0]                cand_mask,
    output logic                            haz,
    output logic [LN_W-1:0]                 lanes,
    output logic [CYC_W-1:0]                hit_cyc
);

    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [OP_SLOTS-1:0] op_live;
    logic [ENTRIES-1:0]  hit;
    logic [IDX_W-1:0]    sel;
    logic [LANES-1:0]    shared;
    logic [LN_W-1:0]     pop;

    // Only strictly positive operand numbers take part.
    always_comb begin
        for (int k = 0; k < OP_SLOTS; k++)
            op_live[k] = !ops[k][REG_W-1] && (ops[k] != '0);
    end

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            logic named;
            named = 1'b0;
            for (int k = 0; k < OP_SLOTS; k++)
                if (op_live[k] && (ops[k] == ent_reg[e])) named = 1'b1;
            hit[e] = ent_vld[e] && named && (|(ent_mask[e] & cand_mask));
        end
    end

    // Lowest-index hitting entry is the one reported.
    always_comb begin
        sel = '0;
        for (int e = ENTRIES - 1; e >= 0; e--)
            if (hit[e]) sel = IDX_W'(e);
        shared = ent_mask[sel] & cand_mask;
        pop    = '0;
        for (int l = 0; l < LANES; l++)
            pop = pop + LN_W'(shared[l]);
    end

    assign haz     = |hit;
    assign lanes   = haz ? pop : '0;
    assign hit_cyc = haz ? ent_cyc[sel] : '0;

endmodule

// File: rtl/lane_resv_table.sv
module lane_resv_table
    import rrt_pkg::*;
#(
    parameter int unsigned WARPS   = 4,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned REG_W   = 8,
    parameter int unsigned LANES   = 32,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned CYC_W   = 32,
    localparam int unsigned WARP_W = (WARPS > 1) ? $clog2(WARPS) : 1,
    localparam int unsigned LN_W   = $clog2(LANES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       res_vld,
    input  logic [WARP_W-1:0]          res_warp,
    input  logic [REG_W-1:0]           res_reg,
    input  logic [LANES-1:0]           res_mask,
    input  logic                       rel_vld,
    input  logic [WARP_W-1:0]          rel_warp,
    input  logic [REG_W-1:0]           rel_reg,
    input  logic [LANES-1:0]           rel_mask,
    input  logic [WARP_W-1:0]          chk_warp,
    input  logic [OP_SLOTS*REG_W-1:0]  chk_ops,
    input  logic [LANES-1:0]           chk_mask,
    output logic                       haz,
    output logic [LN_W-1:0]            haz_lanes,
    output logic [CYC_W-1:0]           haz_cyc,
    output logic                       res_ovf,
    output logic [CYC_W-1:0]           now_cycle
);

    logic [WARPS-1:0][ENTRIES-1:0]             all_vld;
    logic [WARPS-1:0][ENTRIES-1:0][REG_W-1:0]  all_reg;
    logic [WARPS-1:0][ENTRIES-1:0][LANES-1:0]  all_mask;
    logic [WARPS-1:0][ENTRIES-1:0][CYC_W-1:0]  all_cyc;
    logic [WARPS-1:0]                          bank_ovf;
    logic [OP_SLOTS-1:0][REG_W-1:0]            ops_arr;

    assign ops_arr = chk_ops;

    rrt_cycle_ctr #(.CYC_W(CYC_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cyc   (now_cycle)
    );

    for (genvar w = 0; w < WARPS; w++) begin : g_bank
        rrt_warp_bank #(
            .ENTRIES (ENTRIES),
            .REG_W   (REG_W),
            .LANES   (LANES),
            .CNT_W   (CNT_W),
            .CYC_W   (CYC_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .res_en   (res_vld && (res_warp == WARP_W'(w))),
            .res_reg  (res_reg),
            .res_mask (res_mask),
            .rel_en   (rel_vld && (rel_warp == WARP_W'(w))),
            .rel_reg  (rel_reg),
            .rel_mask (rel_mask),
            .now_cyc  (now_cycle),
            .ent_vld  (all_vld[w]),
            .ent_reg  (all_reg[w]),
            .ent_mask (all_mask[w]),
            .ent_cyc  (all_cyc[w]),
            .ovf      (bank_ovf[w])
        );
    end

    rrt_hazard #(
        .ENTRIES  (ENTRIES),
        .REG_W    (REG_W),
        .LANES    (LANES),
        .CYC_W    (CYC_W),
        .OP_SLOTS (OP_SLOTS),
        .LN_W     (LN_W)
    ) u_haz (
        .ent_vld   (all_vld[chk_warp]),
        .ent_reg   (all_reg[chk_warp]),
        .ent_mask  (all_mask[chk_warp]),
        .ent_cyc   (all_cyc[chk_warp]),
        .ops       (ops_arr),
        .cand_mask (chk_mask),
        .haz       (haz),
        .lanes     (haz_lanes),
        .hit_cyc   (haz_cyc)
    );

    assign res_ovf = |bank_ovf;

    // R6: a hazard needs at least one active candidate lane
    a_r6_needs_lane: assert property (@(posedge clk) disable iff (!rst_n)
        haz |-> (chk_mask != '0));

    // R8: reported lane count lies between one and the candidate's lanes
    a_r8_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
        haz |-> (haz_lanes != '0 && 32'(haz_lanes) <= 32'($countones(chk_mask))));

    // R8: no hazard, no lane count
    a_r8_lane_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !haz |-> (haz_lanes == '0));

    // R11: a visible entry was reserved in an earlier cycle
    a_r11_entry_older: assert property (@(posedge clk) disable iff (!rst_n)
        haz |-> (haz_cyc < now_cycle));

    // R10: an overflow flag always follows a reserve request
    a_r10_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        res_ovf |-> $past(res_vld));

endmodule

// File: tb/sim_lane_resv_table.sv
module sim_lane_resv_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_vld = 1'b0, rel_vld = 1'b0;
    logic [1:0]  res_warp = '0, rel_warp = '0, chk_warp = '0;
    logic [7:0]  res_reg = '0, rel_reg = '0;
    logic [31:0] res_mask = '0, rel_mask = '0, chk_mask = '0;
    logic [63:0] chk_ops = '0;
    logic        haz, res_ovf;
    logic [5:0]  haz_lanes;
    logic [31:0] haz_cyc, now_cycle;

    int n_cmp = 0;
    int n_bad = 0;
    logic ovf_ok = 1'b0;
    logic [31:0] rc [0:4];

    always #4 clk = ~clk;

    lane_resv_table u0 (
        .clk(clk), .rst_n(rst_n),
        .res_vld(res_vld), .res_warp(res_warp), .res_reg(res_reg), .res_mask(res_mask),
        .rel_vld(rel_vld), .rel_warp(rel_warp), .rel_reg(rel_reg), .rel_mask(rel_mask),
        .chk_warp(chk_warp), .chk_ops(chk_ops), .chk_mask(chk_mask),
        .haz(haz), .haz_lanes(haz_lanes), .haz_cyc(haz_cyc),
        .res_ovf(res_ovf), .now_cycle(now_cycle)
    );

    typedef struct packed {
        logic [1:0]  warp;
        logic [63:0] ops;
        logic [31:0] mask;
        logic        hz;
        logic [5:0]  lanes;
        logic [2:0]  ent;
    } vec_t;

    // Warp 1 holds: e0 r5 0000FFFF, e1 r5 FFFF0000, e2 r9 00000001, e3 rFB all, e4 r0 all
    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 64'h00000000_00000005, 32'h000000F0, 1'b1, 6'd4,  3'd0},  // R6 R8 dst0
        '{2'd1, 64'h00000005_00000000, 32'h00030000, 1'b1, 6'd2,  3'd1},  // R6 disjoint half skipped
        '{2'd1, 64'h00000900_00000000, 32'h00000002, 1'b0, 6'd0,  3'd0},  // R6 no lane overlap
        '{2'd1, 64'h00000900_00000000, 32'h00000003, 1'b1, 6'd1,  3'd2},  // R7 pred slot
        '{2'd1, 64'hFB000000_00000000, 32'hFFFFFFFF, 1'b0, 6'd0,  3'd0},  // R7 negative ignored
        '{2'd1, 64'h00000000_00000000, 32'hFFFFFFFF, 1'b0, 6'd0,  3'd0},  // R7 zero ignored
        '{2'd1, 64'h00090000_00000000, 32'hFFFFFFFF, 1'b1, 6'd1,  3'd2},  // R7 addr0 slot
        '{2'd1, 64'h00000000_00090500, 32'hFFFFFFFF, 1'b1, 6'd16, 3'd0},  // R8 lowest entry
        '{2'd0, 64'h00000000_00090500, 32'hFFFFFFFF, 1'b0, 6'd0,  3'd0},  // R6 other warp
        '{2'd1, 64'h00000000_00000005, 32'h00000000, 1'b0, 6'd0,  3'd0},  // R6 empty mask
        '{2'd1, 64'h00000000_00000006, 32'hFFFFFFFF, 1'b0, 6'd0,  3'd0}   // R6 other register
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_res(input logic [1:0] w, input logic [7:0] r, input logic [31:0] m);
        res_warp = w; res_reg = r; res_mask = m; res_vld = 1'b1;
        step();
        res_vld = 1'b0;
    endtask

    task automatic do_rel(input logic [1:0] w, input logic [7:0] r, input logic [31:0] m);
        rel_warp = w; rel_reg = r; rel_mask = m; rel_vld = 1'b1;
        step();
        rel_vld = 1'b0;
    endtask

    task automatic probe(input logic [1:0] w, input logic [63:0] o, input logic [31:0] m);
        chk_warp = w; chk_ops = o; chk_mask = m;
        #1;
    endtask

    always @(negedge clk) begin
        if (rst_n && res_ovf && !ovf_ok) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 unexpected overflow actual=1 expected=0");
        end
    end

    initial begin
        #(8 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] c0;
        repeat (3) @(negedge clk);
        probe(2'd1, 64'h5, 32'hFFFFFFFF);
        check("R1 haz", haz, 0);
        check("R1 lanes", haz_lanes, 0);
        check("R1 ovf", res_ovf, 0);
        check("R1 cycle", now_cycle, 0);
        rst_n = 1'b1;

        // R9 counter stride
        c0 = now_cycle;
        repeat (5) step();
        check("R9 stride", now_cycle, c0 + 5);

        // Setup warp 1 (R2 allocation)
        rc[0] = now_cycle; do_res(2'd1, 8'h05, 32'h0000FFFF);
        rc[1] = now_cycle; do_res(2'd1, 8'h05, 32'hFFFF0000);
        rc[2] = now_cycle; do_res(2'd1, 8'h09, 32'h00000001);
        rc[3] = now_cycle; do_res(2'd1, 8'hFB, 32'hFFFFFFFF);
        rc[4] = now_cycle; do_res(2'd1, 8'h00, 32'hFFFFFFFF);

        for (int i = 0; i < NV; i++) begin
            probe(VEC[i].warp, VEC[i].ops, VEC[i].mask);
            check($sformatf("R6 vec%0d haz", i), haz, VEC[i].hz);
            check($sformatf("R8 vec%0d lanes", i), haz_lanes, VEC[i].lanes);
            check($sformatf("R9 vec%0d cyc", i), haz_cyc, VEC[i].hz ? rc[VEC[i].ent] : 32'd0);
        end

        // R11: same-cycle reserve is invisible until the next cycle
        res_warp = 2'd2; res_reg = 8'd11; res_mask = 32'h4; res_vld = 1'b1;
        probe(2'd2, 64'd11, 32'h4);
        check("R11 same cycle", haz, 0);
        step();
        res_vld = 1'b0;
        #1;
        check("R11 next cycle", haz, 1);

        // R3 / R4: two references need two releases
        do_res(2'd2, 8'd7, 32'h1);
        do_res(2'd2, 8'd7, 32'h1);
        probe(2'd2, 64'd7, 32'h1);
        do_rel(2'd2, 8'd7, 32'h1); #1;
        check("R3 held after one release", haz, 1);
        // R5: mask mismatch release ignored
        do_rel(2'd2, 8'd7, 32'h3); #1;
        check("R5 wrong mask release", haz, 1);
        do_rel(2'd2, 8'd7, 32'h1); #1;
        check("R4 freed at zero", haz, 0);

        // R12: simultaneous reserve and release on a count-1 entry
        do_res(2'd2, 8'd7, 32'h1);
        res_warp = 2'd2; res_reg = 8'd7; res_mask = 32'h1; res_vld = 1'b1;
        rel_warp = 2'd2; rel_reg = 8'd7; rel_mask = 32'h1; rel_vld = 1'b1;
        step();
        res_vld = 1'b0; rel_vld = 1'b0; #1;
        check("R12 net zero", haz, 1);
        do_rel(2'd2, 8'd7, 32'h1); #1;
        check("R12 single release clears", haz, 0);

        // R10: full table drops a new key
        for (int r = 1; r <= 8; r++) do_res(2'd3, 8'(r), 32'h1);
        ovf_ok = 1'b1;
        do_res(2'd3, 8'd20, 32'h1);
        check("R10 full ovf", res_ovf, 1);
        probe(2'd3, 64'd20, 32'h1);
        check("R10 dropped", haz, 0);
        step();
        check("R10 ovf one cycle", res_ovf, 0);
        ovf_ok = 1'b0;
        probe(2'd3, 64'd8, 32'h1);
        check("R10 old entry kept", haz, 1);
        do_rel(2'd3, 8'd1, 32'h1);
        do_res(2'd3, 8'd20, 32'h1);
        check("R2 reuse freed slot", res_ovf, 0);
        probe(2'd3, 64'd20, 32'h1);
        check("R2 new entry visible", haz, 1);

        // R10: reference count saturation
        for (int n = 0; n < 15; n++) do_res(2'd0, 8'd30, 32'hF);
        ovf_ok = 1'b1;
        do_res(2'd0, 8'd30, 32'hF);
        check("R10 count ovf", res_ovf, 1);
        step();
        ovf_ok = 1'b0;
        probe(2'd0, 64'd30, 32'h1);
        for (int n = 0; n < 14; n++) do_rel(2'd0, 8'd30, 32'hF);
        #1;
        check("R3 count held at fifteen", haz, 1);
        check("R8 single lane", haz_lanes, 1);
        do_rel(2'd0, 8'd30, 32'hF); #1;
        check("R4 last reference", haz, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule